// File: doc/BRIEF.md
# Dual-Mode Rate Divider

This block turns a fast clock into a stream of single-cycle enable pulses whose rate is set by a 10-bit step value. It has two ways of producing them. In integer mode, a counter is loaded with the step and counts up to its all-ones value, which gives an exact divide by (1024 − step). In fractional mode, the step is added to an accumulator every cycle and a pulse is issued on each carry out of the top bit, which gives an average rate of step/1024 of the input clock. All arithmetic wraps modulo 1024. A second output toggles on every pulse, so it is a square wave at half the pulse rate. Downstream logic can use it as a master clock.

A small state machine holds the active mode. After reset it sits in `ST_IDLE` for one cycle. It then moves to `ST_NORMAL` when the mode input is low, or to `ST_FRACT` when it is high. The transitions are IDLE→NORMAL, IDLE→FRACT, NORMAL→FRACT and FRACT→NORMAL, and the machine also stays in NORMAL or FRACT while the mode input holds. Each transition into NORMAL loads the counter with the current step. Each transition into FRACT clears the accumulator. The cycle in which a transition happens never produces a pulse. The pulse output and the master-clock output both come straight from registers.

Top module: `rate_divider`

## Requirements
- R1: While reset is asserted, and in the single ST_IDLE cycle that follows, `tick_o` and `mclk_o` are both 0.
- R2: With `frac_mode_i` = 0, `tick_o` carries one pulse every (1024 − `step_i`) cycles. After a switch into integer mode, the first pulse follows the switch cycle by (1024 − step) cycles.
- R3: With `frac_mode_i` = 1, each cycle adds `step_i` to a 10-bit accumulator that starts at 0, and a carry out of bit 9 produces a pulse. Over N cycles after the switch cycle, floor(N·step/1024) pulses appear.
- R4: In integer mode with `step_i` = 1023, `tick_o` is 1 on every cycle after the switch cycle.
- R5: In fractional mode with `step_i` = 0, `tick_o` stays 0.
- R6: A change of `frac_mode_i` causes one switch cycle in which no pulse is issued. That cycle reloads the counter (into integer mode) or clears the accumulator (into fractional mode).
- R7: In integer mode, a new `step_i` does not shorten or lengthen the period already running. It is loaded at the next wrap.
- R8: `mclk_o` changes value in exactly the cycles where `tick_o` is 1, so it runs at half the pulse rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| frac_mode_i | input | 1 | 0 = integer divide, 1 = fractional rate |
| step_i | input | 10 | Step value used by both modes |
| tick_o | output | 1 | Single-cycle enable pulse (registered) |
| mclk_o | output | 1 | Toggles on every pulse (half pulse rate) |

## Verification
The bench targets the end points of the step range. A step of 1023 in integer mode must pulse every cycle; a design off by one at the wrap would skip every other cycle. A step of 0 in fractional mode must stay silent; a design that treated 0 as 1024 would pulse continuously. A step of 0 in integer mode must give the longest period, 1024. It also changes the step in the middle of an integer period: a design that compared against the live step rather than the reloaded one would end that period early. Every mode switch must produce one quiet cycle and a fresh start, and the master clock must follow the pulses edge for edge. Any leftover accumulator value or missed toggle shows up as a wrong pulse count.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
    localparam int unsigned STEP_W = 10;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_NORMAL = 2'd1,
        ST_FRACT  = 2'd2
    } rdiv_state_e;
endpackage

// File: rtl/rdiv_int_counter.sv
module rdiv_int_counter #(
    parameter int unsigned W = 10
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic         run_i,
    input  logic [W-1:0] step_i,
    output logic         wrap_o
);
    localparam logic [W-1:0] CNT_TOP = {W{1'b1}};
    localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q;

    assign wrap_o = run_i && (cnt_q == CNT_TOP);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i || wrap_o) begin
            // a new step only enters here, at a reload
            cnt_q <= step_i;
        end else if (run_i) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end
endmodule

// File: rtl/rdiv_frac_accum.sv
module rdiv_frac_accum #(
    parameter int unsigned W = 10
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clear_i,
    input  logic         run_i,
    input  logic [W-1:0] step_i,
    output logic         carry_o
);
    logic [W-1:0] acc_q;
    logic [W:0]   sum;

    assign sum     = {1'b0, acc_q} + {1'b0, step_i};
    assign carry_o = run_i && sum[W];

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            acc_q <= '0;
        end else if (clear_i) begin
            acc_q <= '0;
        end else if (run_i) begin
            acc_q <= sum[W-1:0];
        end
    end
endmodule

// File: rtl/rdiv_half_toggle.sv
module rdiv_half_toggle (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pulse_i,
    output logic tick_o,
    output logic mclk_o
);
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            tick_o <= 1'b0;
            mclk_o <= 1'b0;
        end else begin
            tick_o <= pulse_i;
            mclk_o <= mclk_o ^ pulse_i;
        end
    end
endmodule

// File: rtl/rate_divider.sv
module rate_divider
    import rdiv_pkg::*;
#(
    parameter int unsigned W = STEP_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         frac_mode_i,
    input  logic [W-1:0] step_i,
    output logic         tick_o,
    output logic         mclk_o
);
    rdiv_state_e state_q, state_d;

    logic int_load, int_run, int_wrap;
    logic frac_clear, frac_run, frac_carry;
    logic pulse;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = frac_mode_i ? ST_FRACT : ST_NORMAL;
            ST_NORMAL: state_d = frac_mode_i ? ST_FRACT : ST_NORMAL;
            ST_FRACT:  state_d = frac_mode_i ? ST_FRACT : ST_NORMAL;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath controls
    always_comb begin
        int_load   = 1'b0;
        int_run    = 1'b0;
        frac_clear = 1'b0;
        frac_run   = 1'b0;
        unique case (state_q)
            ST_NORMAL: begin
                int_run    = (state_d == ST_NORMAL);
                frac_clear = (state_d == ST_FRACT);
            end
            ST_FRACT: begin
                frac_run = (state_d == ST_FRACT);
                int_load = (state_d == ST_NORMAL);
            end
            default: begin
                int_load   = (state_d == ST_NORMAL);
                frac_clear = (state_d == ST_FRACT);
            end
        endcase
    end

    rdiv_int_counter #(.W(W)) u_int (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (int_load),
        .run_i  (int_run),
        .step_i (step_i),
        .wrap_o (int_wrap)
    );

    rdiv_frac_accum #(.W(W)) u_frac (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (frac_clear),
        .run_i   (frac_run),
        .step_i  (step_i),
        .carry_o (frac_carry)
    );

    assign pulse = int_wrap | frac_carry;

    rdiv_half_toggle u_out (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pulse_i (pulse),
        .tick_o  (tick_o),
        .mclk_o  (mclk_o)
    );
endmodule

// File: rtl/rate_divider_checker.sv
module rate_divider_checker
    import rdiv_pkg::*;
#(
    parameter int unsigned W = STEP_W
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         frac_mode_i,
    input logic [W-1:0] step_i,
    input logic         tick_o,
    input logic         mclk_o,
    input rdiv_state_e  state_q
);
    localparam logic [W-1:0] STEP_MAX = {W{1'b1}};

    a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE) |-> (!tick_o && !mclk_o));

    a_r8_mclk_follows_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mclk_o != $past(mclk_o)) == tick_o);

    a_r5_zero_step_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_FRACT && frac_mode_i && step_i == '0) |=> !tick_o);

    a_r4_full_step_every_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_NORMAL && !frac_mode_i && step_i == STEP_MAX && tick_o
         && $past(step_i) == STEP_MAX) |=> tick_o);

    a_r6_to_fract_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_NORMAL && frac_mode_i) |=> !tick_o);

    a_r6_to_normal_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_FRACT && !frac_mode_i) |=> !tick_o);
endmodule

bind rate_divider rate_divider_checker #(.W(W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frac_mode_i (frac_mode_i),
    .step_i      (step_i),
    .tick_o      (tick_o),
    .mclk_o      (mclk_o),
    .state_q     (state_q)
);

// File: tb/rate_divider_test.sv
module rate_divider_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frac_mode = 1'b0;
    logic [9:0] step = 10'd0;
    logic       tick, mclk;

    int n_checks = 0;
    int n_fail   = 0;
    int tick_seen = 0;
    int mclk_flips = 0;
    bit done = 0;

    // reference state
    int m_state = 0;    // 0 idle, 1 integer, 2 fractional
    int m_cnt = 0;
    int m_acc = 0;
    bit m_tick = 0;
    bit m_mclk = 0;
    bit last_mclk = 0;

    always #4 clk = ~clk;

    rate_divider uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .frac_mode_i (frac_mode),
        .step_i      (step),
        .tick_o      (tick),
        .mclk_o      (mclk)
    );

    function automatic int exp_int_ticks(int s, int n);
        return n / (1024 - s);
    endfunction

    function automatic int exp_frac_ticks(int s, int n);
        return (n * s) / 1024;
    endfunction

    task automatic check_eq(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int want;
        int s;
        bit p;
        want = frac_mode ? 2 : 1;
        p = 0;
        if (m_state == want) begin
            if (want == 1) begin
                if (m_cnt == 1023) begin p = 1; m_cnt = int'(step); end
                else m_cnt++;
            end else begin
                s = m_acc + int'(step);
                p = (s >= 1024);
                m_acc = s % 1024;
            end
        end else begin
            if (want == 1) m_cnt = int'(step);
            else m_acc = 0;
        end
        m_state = want;
        m_tick = p;
        m_mclk = m_mclk ^ p;
    endtask

    task automatic run_cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_eq(m_state == 2 ? "R3 tick" : "R2 tick", int'(tick), int'(m_tick));
        check_eq("R8 mclk", int'(mclk), int'(m_mclk));
        if (tick) tick_seen++;
        if (mclk != last_mclk) mclk_flips++;
        last_mclk = mclk;
    endtask

    task automatic rate_check(bit mode, int s, int n, int exp, string req);
        frac_mode = !mode;
        run_cycle();
        run_cycle();
        frac_mode = mode;
        step = s[9:0];
        run_cycle();
        check_eq("R6 switch cycle quiet", int'(tick), 0);
        tick_seen = 0;
        mclk_flips = 0;
        repeat (n) run_cycle();
        check_eq(req, tick_seen, exp);
        check_eq("R8 flips equal pulses", mclk_flips, tick_seen);
    endtask

    task automatic r7_check();
        int first_at = -1;
        int second_at = -1;
        frac_mode = 1'b1;
        run_cycle();
        run_cycle();
        frac_mode = 1'b0;
        step = 10'd1000;
        run_cycle();
        for (int i = 1; i <= 40; i++) begin
            if (i == 11) step = 10'd1020;
            run_cycle();
            if (tick) begin
                if (first_at < 0) first_at = i;
                else if (second_at < 0) second_at = i;
            end
        end
        check_eq("R7 running period kept", first_at, 24);
        check_eq("R7 new step at reload", second_at, 28);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20417));
        repeat (3) @(negedge clk);
        check_eq("R1 tick in reset", int'(tick), 0);
        check_eq("R1 mclk in reset", int'(mclk), 0);
        rst_n = 1'b1;
        run_cycle();
        check_eq("R1 tick idle cycle", int'(tick), 0);
        check_eq("R1 mclk idle cycle", int'(mclk), 0);

        rate_check(1'b0, 1000, 240, exp_int_ticks(1000, 240), "R2 period 24");
        rate_check(1'b0, 0, 3072, exp_int_ticks(0, 3072), "R2 period 1024");
        rate_check(1'b0, 1023, 50, 50, "R4 every cycle");
        rate_check(1'b1, 0, 500, 0, "R5 zero step silent");
        rate_check(1'b1, 1, 2048, exp_frac_ticks(1, 2048), "R3 step 1");
        rate_check(1'b1, 768, 400, exp_frac_ticks(768, 400), "R3 step 768");
        rate_check(1'b1, 1023, 1024, exp_frac_ticks(1023, 1024), "R3 step 1023");
        r7_check();

        for (int seg = 0; seg < 40; seg++) begin
            int len;
            int pick;
            frac_mode = 1'($urandom_range(0, 1));
            pick = int'($urandom_range(0, 5));
            if (pick == 0) step = 10'd0;
            else if (pick == 1) step = 10'd1023;
            else if (pick == 2) step = 10'($urandom_range(1000, 1023));
            else step = 10'($urandom_range(0, 1023));
            len = int'($urandom_range(20, 300));
            for (int c = 0; c < len; c++) begin
                if ($urandom_range(0, 99) == 0) step = 10'($urandom_range(990, 1023));
                run_cycle();
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule